// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of a four-bank SDRAM and keeps the array refreshed. A free-running interval timer, sized in clock cycles from a clock-frequency parameter and a refresh-period parameter, records one owed refresh each time it expires. To pay what is owed, the block asks the access arbiter for the command bus. Once the bus is granted it closes every bank with a precharge-all and then issues auto-refresh commands back to back until nothing is owed. It then drops its request and hands the bus back.

The same handshake carries low-power entry. While the self-refresh request input is high, the block takes the bus, closes all banks, and issues the self-refresh entry command, which drops the clock-enable pin. It keeps clock enable low for as long as the request stays high. When the request falls, it raises clock enable and drives no-operation cycles for a programmable recovery time before releasing the bus. No refreshes are owed while the device refreshes itself, so the interval timer is halted and cleared during that time.

Top module: `sdr_refresh_seq`

## Requirements
- R1: While reset is asserted, `refReq` is low, `sdCke` is high, the pins carry a no-operation command and `sdA10` is low.
- R2: On any cycle without a command to issue, the pins carry no-operation (`sdCsN` low, `sdRasN`, `sdCasN` and `sdWeN` high). No pin combination outside no-operation, precharge-all, auto-refresh and self-refresh entry ever appears.
- R3: The interval is INTERVAL = CLK_MHZ*REFI_NS/1000 cycles. One refresh is owed INTERVAL cycles after reset or after the timer restarts, and one more every INTERVAL cycles after that. `refReq` is seen high on the cycle the debt appears. When the grant comes at once, auto-refresh commands are spaced exactly INTERVAL cycles apart. Every interval that elapses is paid for once the debt stays below the cap.
- R4: A command other than no-operation appears only after `arbGrant` was high on the cycle before the first command of a session, and only while `refReq` is high. `refReq` stays high from the request until the session ends.
- R5: A refresh session starts with precharge-all (`sdCsN`, `sdRasN`, `sdWeN` low, `sdCasN` high, `sdA10` high). Auto-refresh (`sdCsN`, `sdRasN`, `sdCasN` low, `sdWeN` high, `sdCke` high) follows T_RP+1 cycles after the precharge. Each further auto-refresh follows T_RFC+1 cycles after the one before.
- R6: At most MAX_POSTPONE refreshes (8 by default) are owed at once, and extra expiries are dropped. All owed refreshes are issued in one granted session behind a single precharge-all.
- R7: When `srReq` is high, the granted session issues precharge-all. T_RP+1 cycles later, or T_RFC+1 cycles after an auto-refresh already under way, it issues self-refresh entry (`sdCsN`, `sdRasN`, `sdCasN`, `sdCke` low, `sdWeN` high). Any owed refreshes are discarded without an auto-refresh.
- R8: While `srReq` remains high after entry, `sdCke` stays low, the pins carry no-operation, `refReq` stays high and no refresh is issued.
- R9: After `srReq` falls, `sdCke` returns high and T_XSR cycles of no-operation with `refReq` high follow. `refReq` then falls. The next refresh is owed exactly INTERVAL cycles after `refReq` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| arbGrant | input | 1 | Bus grant from the access arbiter |
| srReq | input | 1 | Hold high to enter and stay in self-refresh |
| refReq | output | 1 | Bus request to the access arbiter |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdA10 | output | 1 | Address bit 10, high selects all banks on precharge |
| sdCke | output | 1 | Clock enable |

## Verification
The assertions take for granted an arbiter that raises `arbGrant` only while `refReq` is high and keeps it there until `refReq` falls. They also assume `srReq` changes only between clock edges. The bench's grant driver keeps to this contract in every mode. It never grants, grants at once, or grants after a random wait of up to three intervals, and it always lets go when the request drops. The random waits keep the owed count well below the cap, so every elapsed interval must show up as exactly one auto-refresh. A separate directed case pushes the count past the cap.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PRE_WAIT,
    ST_REF,
    ST_REF_WAIT,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT
  } seqState_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_SRE
  } sdrCmd_e;

  typedef enum logic [1:0] {
    WAIT_RP,
    WAIT_RFC,
    WAIT_XSR
  } waitSel_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     timerRun;
    logic     owedClr;
    logic     owedDec;
    logic     waitLoad;
    waitSel_e waitSel;
    sdrCmd_e  cmd;
    logic     ckeOn;
  } seqStrobe_t;

endpackage

// File: rtl/sdr_refresh_ctrl.sv
module sdr_refresh_ctrl
  import sdr_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       arbGrant,
  input  logic       srReq,
  input  logic       owedNz,
  input  logic       waitDone,
  output logic       refReq,
  output seqStrobe_t strb
);

  seqState_e st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt  = st;
    strb = '{timerRun: 1'b1, owedClr: 1'b0, owedDec: 1'b0, waitLoad: 1'b0,
             waitSel: WAIT_RP, cmd: CMD_NOP, ckeOn: 1'b1};
    case (st)
      ST_IDLE: begin
        if (arbGrant && (owedNz || srReq)) nxt = ST_PRE;
      end
      ST_PRE: begin
        strb.cmd      = CMD_PRE;
        strb.waitLoad = 1'b1;
        strb.waitSel  = WAIT_RP;
        nxt           = ST_PRE_WAIT;
      end
      ST_PRE_WAIT, ST_REF_WAIT: begin
        if (waitDone) begin
          if (srReq)       nxt = ST_SR_ENTER;
          else if (owedNz) nxt = ST_REF;
          else             nxt = ST_IDLE;
        end
      end
      ST_REF: begin
        strb.cmd      = CMD_REF;
        strb.owedDec  = 1'b1;
        strb.waitLoad = 1'b1;
        strb.waitSel  = WAIT_RFC;
        nxt           = ST_REF_WAIT;
      end
      ST_SR_ENTER: begin
        strb.cmd      = CMD_SRE;
        strb.ckeOn    = 1'b0;
        strb.timerRun = 1'b0;
        strb.owedClr  = 1'b1;
        nxt           = ST_SR_HOLD;
      end
      ST_SR_HOLD: begin
        strb.ckeOn    = 1'b0;
        strb.timerRun = 1'b0;
        strb.owedClr  = 1'b1;
        strb.waitLoad = 1'b1;
        strb.waitSel  = WAIT_XSR;
        if (!srReq) nxt = ST_SR_EXIT;
      end
      ST_SR_EXIT: begin
        strb.timerRun = 1'b0;
        strb.owedClr  = 1'b1;
        if (waitDone) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign refReq = (st != ST_IDLE) || owedNz || srReq;

  // R4: a session only starts on a granted cycle
  p_grant_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st) == ST_IDLE && st != ST_IDLE) |-> $past(arbGrant));

  // R5: auto-refresh only after the banks were closed in this session
  p_pre_before_ref_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REF) |-> ($past(st) == ST_PRE_WAIT || $past(st) == ST_REF_WAIT));

  // R7: self-refresh entry only from a closed-bank wait state
  p_closed_before_sre_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SR_ENTER) |-> ($past(st) == ST_PRE_WAIT || $past(st) == ST_REF_WAIT));

  // R8: self-refresh is held while the request stays high
  p_sr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SR_HOLD && srReq) |=> (st == ST_SR_HOLD));

endmodule

// File: rtl/sdr_refresh_dp.sv
module sdr_refresh_dp
  import sdr_refresh_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int REFI_NS      = 15625,
  parameter int MAX_POSTPONE = 8,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 7,
  parameter int T_XSR        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       owedNz,
  output logic       waitDone,
  output logic       sdCsN,
  output logic       sdRasN,
  output logic       sdCasN,
  output logic       sdWeN,
  output logic       sdA10,
  output logic       sdCke
);

  localparam int INTERVAL = CLK_MHZ * REFI_NS / 1000;
  localparam int CNT_W    = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int OWED_W   = $clog2(MAX_POSTPONE + 1);
  localparam int WAIT_MAX = (T_RP > T_RFC) ? ((T_RP > T_XSR) ? T_RP : T_XSR)
                                           : ((T_RFC > T_XSR) ? T_RFC : T_XSR);
  localparam int WAIT_W   = (WAIT_MAX > 1) ? $clog2(WAIT_MAX + 1) : 1;

  logic [CNT_W-1:0]  cnt;
  logic [OWED_W-1:0] owed;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitInit;
  logic              tick;
  logic              owedInc;

  // Interval timer
  assign tick = strb.timerRun && (cnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (!strb.timerRun) cnt <= '0;
    else if (tick)          cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // Owed-refresh counter, saturating at the postponement cap
  assign owedInc = tick && ((owed < OWED_W'(MAX_POSTPONE)) || strb.owedDec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          owed <= '0;
    else if (strb.owedClr)              owed <= '0;
    else if (owedInc && !strb.owedDec)  owed <= owed + 1'b1;
    else if (!owedInc && strb.owedDec)  owed <= owed - 1'b1;
  end

  assign owedNz = (owed != '0);

  // Spacing counter, one preset per wait kind
  always_comb begin
    case (strb.waitSel)
      WAIT_RP:  waitInit = WAIT_W'(T_RP - 1);
      WAIT_RFC: waitInit = WAIT_W'(T_RFC - 1);
      default:  waitInit = WAIT_W'(T_XSR - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               waitCnt <= '0;
    else if (strb.waitLoad)  waitCnt <= waitInit;
    else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == '0);

  // Command pin decode
  always_comb begin
    sdCsN  = 1'b0;
    sdRasN = 1'b1;
    sdCasN = 1'b1;
    sdWeN  = 1'b1;
    sdA10  = 1'b0;
    case (strb.cmd)
      CMD_PRE: begin
        sdRasN = 1'b0;
        sdWeN  = 1'b0;
        sdA10  = 1'b1;
      end
      CMD_REF, CMD_SRE: begin
        sdRasN = 1'b0;
        sdCasN = 1'b0;
      end
      default: ;
    endcase
  end

  assign sdCke = strb.ckeOn;

  // R6: the owed count never exceeds the cap
  p_owed_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    owed <= OWED_W'(MAX_POSTPONE));

  // R6: a refresh is only paid when one is owed
  p_dec_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.owedDec |-> (owed != '0));

  // R8: a halted timer leaves nothing owed
  p_timer_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.timerRun |=> (cnt == '0 && owed == '0));

  // R7: clock enable falls only with the self-refresh entry command
  p_cke_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdCke) |-> (!sdCsN && !sdRasN && !sdCasN && sdWeN));

endmodule

// File: rtl/sdr_refresh_seq.sv
module sdr_refresh_seq
  import sdr_refresh_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int REFI_NS      = 15625,
  parameter int MAX_POSTPONE = 8,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 7,
  parameter int T_XSR        = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic arbGrant,
  input  logic srReq,
  output logic refReq,
  output logic sdCsN,
  output logic sdRasN,
  output logic sdCasN,
  output logic sdWeN,
  output logic sdA10,
  output logic sdCke
);

  seqStrobe_t strb;
  logic       owedNz;
  logic       waitDone;

  sdr_refresh_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .arbGrant (arbGrant),
    .srReq    (srReq),
    .owedNz   (owedNz),
    .waitDone (waitDone),
    .refReq   (refReq),
    .strb     (strb)
  );

  sdr_refresh_dp #(
    .CLK_MHZ      (CLK_MHZ),
    .REFI_NS      (REFI_NS),
    .MAX_POSTPONE (MAX_POSTPONE),
    .T_RP         (T_RP),
    .T_RFC        (T_RFC),
    .T_XSR        (T_XSR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .owedNz   (owedNz),
    .waitDone (waitDone),
    .sdCsN    (sdCsN),
    .sdRasN   (sdRasN),
    .sdCasN   (sdCasN),
    .sdWeN    (sdWeN),
    .sdA10    (sdA10),
    .sdCke    (sdCke)
  );

endmodule

// File: tb/sdr_refresh_seq_bench.sv
module sdr_refresh_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 8;
  localparam int REFI_NS    = 8000;
  localparam int INTERVAL   = CLK_MHZ * REFI_NS / 1000;
  localparam int MAXP       = 8;
  localparam int T_RP       = 2;
  localparam int T_RFC      = 4;
  localparam int T_XSR      = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arbGrant = 1'b0;
  logic srReq = 1'b0;
  logic refReq, sdCsN, sdRasN, sdCasN, sdWeN, sdA10, sdCke;

  sdr_refresh_seq #(
    .CLK_MHZ(CLK_MHZ), .REFI_NS(REFI_NS), .MAX_POSTPONE(MAXP),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_XSR(T_XSR)
  ) u_sdr_refresh_seq (
    .clk(clk), .rstN(rstN), .arbGrant(arbGrant), .srReq(srReq),
    .refReq(refReq), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdA10(sdA10), .sdCke(sdCke)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int wdCyc   = 0;
  int mode    = 0;   // 0 none, 1 immediate, 2 random latency
  int refCnt  = 0;
  int preCnt  = 0;
  int sreCnt  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expBurst(input int ticks);
    return (ticks > MAXP) ? MAXP : ticks;
  endfunction

  function automatic int expTicks(input int span);
    return span / INTERVAL;
  endfunction

  function automatic int expGap(input int prevKind);
    return (prevKind == 1) ? T_RP + 1 : T_RFC + 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // Watchdog
  always @(posedge clk) begin
    wdCyc++;
    if (wdCyc > 190000) begin
      chk(1'b0, "R4 watchdog cycles", wdCyc, 190000);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  // Grant driver
  int  lat = 0;
  bit  latArmed = 0;
  always begin
    @(posedge clk);
    #3;
    case (mode)
      0: arbGrant = 1'b0;
      1: arbGrant = refReq;
      default: begin
        if (arbGrant) begin
          if (!refReq) arbGrant = 1'b0;
        end else if (refReq) begin
          if (!latArmed) begin
            lat = $urandom_range(0, 3 * INTERVAL);
            latArmed = 1;
          end else if (lat == 0) begin
            arbGrant = 1'b1;
            latArmed = 0;
          end else begin
            lat--;
          end
        end
      end
    endcase
  end

  // Pin monitor: command legality, grant ordering and spacing
  int lastKind = 0;  // 0 none, 1 precharge, 2 refresh, 3 self-refresh entry
  int lastCyc  = 0;
  bit prevGrant = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      lastKind  = 0;
      prevGrant = 0;
    end else begin
      bit isNop, isPre, isRef, isSre;
      isNop = !sdCsN && sdRasN && sdCasN && sdWeN;
      isPre = !sdCsN && !sdRasN && sdCasN && !sdWeN;
      isRef = !sdCsN && !sdRasN && !sdCasN && sdWeN && sdCke;
      isSre = !sdCsN && !sdRasN && !sdCasN && sdWeN && !sdCke;
      if (!isNop) begin
        chk(refReq, "R4 command while requesting", int'(refReq), 1);
        if (isPre && lastKind != 2 && lastKind != 1)
          chk(prevGrant, "R4 session start after grant", int'(prevGrant), 1);
      end
      if (isPre) begin
        chk(sdA10, "R5 precharge selects all banks", int'(sdA10), 1);
        preCnt++;
        lastKind = 1;
        lastCyc  = cyc;
      end else if (isRef) begin
        chk(lastKind == 1 || lastKind == 2, "R5 refresh preceded by precharge", lastKind, 1);
        chk(cyc - lastCyc == expGap(lastKind), "R5 refresh spacing", cyc - lastCyc, expGap(lastKind));
        refCnt++;
        lastKind = 2;
        lastCyc  = cyc;
      end else if (isSre) begin
        chk(lastKind == 1 || lastKind == 2, "R7 entry preceded by precharge", lastKind, 1);
        chk(cyc - lastCyc == expGap(lastKind), "R7 entry spacing", cyc - lastCyc, expGap(lastKind));
        sreCnt++;
        lastKind = 3;
        lastCyc  = cyc;
      end else if (!isNop) begin
        chk(1'b0, "R2 illegal pin combination",
            int'({sdCsN, sdRasN, sdCasN, sdWeN}), 4'b0111);
      end
      prevGrant = arbGrant;
    end
  end

  task automatic drive();
    @(posedge clk);
    #2;
  endtask

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    mode  = 0;
    srReq = 1'b0;
    rstN  = 1'b0;
    repeat (3) drive();
    rstN = 1'b1;
  endtask

  task automatic waitCyc(input int target);
    while (cyc < target) begin
      @(posedge clk);
      #1;
    end
    #1;
  endtask

  initial begin
    int r0, p0, s0, f, fEnd, n, bad, riseCyc;
    int refAt [3];
    bit seen;
    void'($urandom(32'h5eed1234));

    // R1: reset state
    rstN = 1'b0;
    repeat (2) sample();
    chk(!refReq, "R1 request low in reset", int'(refReq), 0);
    chk(sdCke, "R1 clock enable high in reset", int'(sdCke), 1);
    chk({sdCsN, sdRasN, sdCasN, sdWeN, sdA10} == 5'b01110, "R1 no-operation in reset",
        int'({sdCsN, sdRasN, sdCasN, sdWeN, sdA10}), 5'b01110);
    doReset();

    // R2: idle after reset
    sample();
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0111 && sdCke, "R2 idle no-operation",
        int'({sdCsN, sdRasN, sdCasN, sdWeN}), 4'b0111);

    // R3: first debt time and steady spacing with immediate grant
    mode = 1;
    riseCyc = -1;
    n = 0;
    r0 = refCnt;
    for (int k = 0; k < 4 * INTERVAL && n < 3; k++) begin
      sample();
      if (refReq && riseCyc < 0) riseCyc = cyc;
      if (refCnt != r0) begin
        refAt[n] = cyc;
        n++;
        r0 = refCnt;
      end
    end
    chk(riseCyc == INTERVAL, "R3 first request time", riseCyc, INTERVAL);
    chk(n == 3, "R3 refreshes seen", n, 3);
    chk(refAt[1] - refAt[0] == INTERVAL, "R3 refresh period", refAt[1] - refAt[0], INTERVAL);
    chk(refAt[2] - refAt[1] == INTERVAL, "R3 refresh period", refAt[2] - refAt[1], INTERVAL);
    chk(preCnt == refCnt, "R5 one precharge per single refresh", preCnt, refCnt);

    // R6: postponement beyond the cap
    doReset();
    waitCyc(12 * INTERVAL + 2);
    r0 = refCnt;
    p0 = preCnt;
    mode = 1;
    repeat (3) sample();
    for (int k = 0; k < 200 && refReq; k++) sample();
    chk(refCnt - r0 == expBurst(12), "R6 capped burst length", refCnt - r0, expBurst(12));
    chk(preCnt - p0 == 1, "R6 single precharge per burst", preCnt - p0, 1);

    // R7: self-refresh entry discards owed refreshes
    doReset();
    waitCyc(3 * INTERVAL + 8);
    r0 = refCnt;
    p0 = preCnt;
    s0 = sreCnt;
    srReq = 1'b1;
    mode  = 1;
    for (int k = 0; k < 50 && sreCnt == s0; k++) sample();
    chk(sreCnt - s0 == 1, "R7 entry issued", sreCnt - s0, 1);
    chk(preCnt - p0 == 1, "R7 banks closed first", preCnt - p0, 1);
    chk(refCnt == r0, "R7 owed refreshes discarded", refCnt - r0, 0);

    // R8: hold
    bad = 0;
    for (int k = 0; k < 5 * INTERVAL; k++) begin
      sample();
      if (sdCke || !refReq || !(!sdCsN && sdRasN && sdCasN && sdWeN)) bad++;
    end
    chk(bad == 0, "R8 clock enable low with no-operation", bad, 0);
    chk(refCnt == r0 && preCnt - p0 == 1, "R8 no commands while held", refCnt - r0, 0);

    // R9: exit recovery and timer restart
    drive();
    srReq = 1'b0;
    n = 0;
    bad = 0;
    seen = 0;
    f = -1;
    for (int k = 0; k < 60 && f < 0; k++) begin
      sample();
      if (sdCke) begin
        seen = 1;
        if (refReq) begin
          n++;
          if (!(!sdCsN && sdRasN && sdCasN && sdWeN)) bad++;
        end else begin
          f = cyc;
        end
      end
    end
    chk(seen && n == T_XSR, "R9 recovery cycles", n, T_XSR);
    chk(bad == 0, "R9 no-operation during recovery", bad, 0);
    r0 = refCnt;
    riseCyc = -1;
    for (int k = 0; k < 2 * INTERVAL && riseCyc < 0; k++) begin
      sample();
      if (refReq) riseCyc = cyc;
    end
    chk(riseCyc - f == INTERVAL, "R9 timer restarts on release", riseCyc - f, INTERVAL);

    // R3/R6: random grant latency, every interval paid
    mode = 2;
    p0 = preCnt;
    for (int k = 0; k < 40000 && preCnt - p0 < 30; k++) sample();
    mode = 1;
    repeat (2) sample();
    fEnd = -1;
    for (int k = 0; k < 400 && fEnd < 0; k++) begin
      sample();
      if (!refReq) fEnd = cyc;
    end
    chk(fEnd > 0, "R3 random phase settles", fEnd, 1);
    chk(refCnt - r0 == expTicks(fEnd - f), "R3 refreshes match elapsed intervals",
        refCnt - r0, expTicks(fEnd - f));

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule